// File: doc/BRIEF.md
# Configuration Access Address Translator

This block sits in front of a configuration-space access path. It takes one configuration request per handshake, described by a bus number, a device number, a function number, a register offset and a read/write flag. It decides whether the request goes to the local register window of the root port itself or to a remote configuration window. It also picks the configuration transaction type code, holds the identifier that the remote window must target, and aligns the register offset to a dword. The bus transfer itself and the address translation hardware that uses these outputs belong to the logic downstream.

Targets that cannot be present are screened out before any access. The local bus carries only two device slots and the bus directly below it carries only one. A screened-out read completes normally with all-ones data. A screened-out write completes with an error. Neither one reaches either window. The translation is registered. A result appears one cycle after its request is accepted and stays on the outputs until the consumer takes it.

Top module: `cfg_xlate`

## Requirements
- R1: A request to bus 0 selects the local window (`rsp_local` = 1), and it leaves `rsp_target` unchanged.
- R2: `rsp_type` is 4 (type-0 configuration) for buses 0 and 1, and it is 5 (type-1 configuration) for buses 2 to 255.
- R3: An accepted valid request to any bus other than 0 loads `rsp_target` with bus in bits 31:24, device in bits 23:19 and function in bits 18:16. All other bits are zero. A request to any bus other than 0 selects the remote window (`rsp_local` = 0).
- R4: `rsp_off` equals the request offset with its two low bits cleared.
- R5: A request is invalid when it goes to bus 0 with a device number above 1, or to bus 1 with a device number above 0. `rsp_abort` is 1 exactly for invalid requests. `rsp_target` is not updated by an invalid request.
- R6: An invalid read completes with `rsp_rdata` = 0xFFFFFFFF and `rsp_err` = 0. A valid request gives `rsp_rdata` = 0 and `rsp_err` = 0.
- R7: An invalid write completes with `rsp_err` = 1.
- R8: `req_ready` is 1 whenever no result is held or `rsp_ready` is 1. An accepted request yields `rsp_valid` on the next cycle. A result that is not taken keeps all of its fields stable. When no new request is accepted, a result that is taken clears `rsp_valid`.
- R9: After a synchronous active-low reset, `rsp_valid` is 0 and `rsp_target` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = configuration write, 0 = read |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 5 | Target device number |
| req_fn | input | 3 | Target function number |
| req_off | input | 12 | Register byte offset |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_local | output | 1 | 1 = local register window, 0 = remote configuration window |
| rsp_type | output | 3 | Configuration type code (4 or 5) |
| rsp_target | output | 32 | Held remote target identifier |
| rsp_off | output | 12 | Dword-aligned offset |
| rsp_abort | output | 1 | Request screened out; no access is made |
| rsp_err | output | 1 | Screened-out write error |
| rsp_rdata | output | 32 | Completion data for a screened-out read |

## Verification
The embedded assertions check several properties on every cycle. The type code stays within its two legal values. The returned offset is always aligned. Every accepted request produces a result one cycle later. A stalled result holds still. A bus-0 request or a screened-out request never disturbs the target register. A screened-out read and a screened-out write each complete with their own data and error signature. The bench covers the rest with a behavioural model: the exact packed field positions, the screening boundary at each device number, the split of the type code between buses 1 and 2, and the persistence of the target across a chain of mixed local, remote and rejected requests under random back-pressure.

// File: rtl/cfgx_pkg.sv
// Shared constants and types of the configuration access translator.
// Assumes a fixed 3-bit transaction type code.
package cfgx_pkg;
    localparam logic [2:0] CFGX_TYPE_NEAR = 3'd4;   // type-0 configuration
    localparam logic [2:0] CFGX_TYPE_FAR  = 3'd5;   // type-1 configuration

    typedef struct packed {
        logic       is_local;
        logic [2:0] kind;
        logic       bad;
    } cfgx_route_t;
endpackage

// File: rtl/cfgx_screen.sv
// Screens out requests to device slots that cannot exist on the two
// closest buses. Purely combinational. Assumes bus 0 is the local bus.
module cfgx_screen #(
    parameter int BUS_W     = 8,
    parameter int DEV_W     = 5,
    parameter int LOCAL_DEV = 2,   // device slots on bus 0
    parameter int NEXT_DEV  = 1    // device slots on bus 1
) (
    input  logic [BUS_W-1:0] bus,
    input  logic [DEV_W-1:0] dev,
    output logic             bad
);
    localparam logic [BUS_W-1:0] BUS_LOCAL = '0;
    localparam logic [BUS_W-1:0] BUS_NEXT  = BUS_W'(1);
    localparam logic [DEV_W-1:0] LIM_LOCAL = DEV_W'(LOCAL_DEV);
    localparam logic [DEV_W-1:0] LIM_NEXT  = DEV_W'(NEXT_DEV);

    // flag a device number beyond the slot count of its bus
    always_comb begin
        bad = 1'b0;
        if (bus == BUS_LOCAL && dev >= LIM_LOCAL) bad = 1'b1;
        if (bus == BUS_NEXT  && dev >= LIM_NEXT)  bad = 1'b1;
    end
endmodule

// File: rtl/cfgx_route.sv
// Works out the window, the type code, the packed remote identifier and
// the aligned offset of one request. Combinational. Assumes the packed
// fields fit in TGT_W bits, top-aligned in bus, device, function order.
module cfgx_route #(
    parameter int BUS_W     = 8,
    parameter int DEV_W     = 5,
    parameter int FN_W      = 3,
    parameter int OFF_W     = 12,
    parameter int TGT_W     = 32,
    parameter int ALIGN_B   = 2,   // low offset bits cleared
    parameter int NEAR_BUSES = 2   // buses using type-0 access
) (
    input  logic [BUS_W-1:0]  bus,
    input  logic [DEV_W-1:0]  dev,
    input  logic [FN_W-1:0]   fn,
    input  logic [OFF_W-1:0]  off,
    input  logic              bad,
    output cfgx_pkg::cfgx_route_t route,
    output logic [TGT_W-1:0]  packed_id,
    output logic [OFF_W-1:0]  off_al
);
    localparam int BUS_LSB = TGT_W - BUS_W;
    localparam int DEV_LSB = BUS_LSB - DEV_W;
    localparam int FN_LSB  = DEV_LSB - FN_W;
    localparam logic [BUS_W-1:0] NEAR_LIM = BUS_W'(NEAR_BUSES);

    // window and type selection from the bus number
    always_comb begin
        route.is_local = (bus == '0);
        route.kind     = (bus < NEAR_LIM) ? cfgx_pkg::CFGX_TYPE_NEAR
                                          : cfgx_pkg::CFGX_TYPE_FAR;
        route.bad      = bad;
    end

    // place bus, device and function into the remote identifier
    always_comb begin
        packed_id = '0;
        packed_id[BUS_LSB +: BUS_W] = bus;
        packed_id[DEV_LSB +: DEV_W] = dev;
        packed_id[FN_LSB  +: FN_W]  = fn;
    end

    // clear the sub-dword offset bits, one bit per generated slice
    genvar gi;
    generate
        for (gi = 0; gi < OFF_W; gi++) begin : g_al
            if (gi < ALIGN_B) begin : g_zero
                assign off_al[gi] = 1'b0;
            end else begin : g_keep
                assign off_al[gi] = off[gi];
            end
        end
    endgenerate
endmodule

// File: rtl/cfg_xlate.sv
// Configuration access translator top. Accepts one request per handshake
// and presents the registered translation one cycle later. It holds the
// remote target identifier between requests. Assumes the consumer takes
// a result with rsp_valid && rsp_ready.
module cfg_xlate #(
    parameter int BUS_W = 8,
    parameter int DEV_W = 5,
    parameter int FN_W  = 3,
    parameter int OFF_W = 12,
    parameter int TGT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [BUS_W-1:0] req_bus,
    input  logic [DEV_W-1:0] req_dev,
    input  logic [FN_W-1:0]  req_fn,
    input  logic [OFF_W-1:0] req_off,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic             rsp_local,
    output logic [2:0]       rsp_type,
    output logic [TGT_W-1:0] rsp_target,
    output logic [OFF_W-1:0] rsp_off,
    output logic             rsp_abort,
    output logic             rsp_err,
    output logic [TGT_W-1:0] rsp_rdata
);
    logic                  scr_bad;
    cfgx_pkg::cfgx_route_t rt;
    logic [TGT_W-1:0]      pid;
    logic [OFF_W-1:0]      aoff;
    logic                  acc;

    cfgx_screen #(.BUS_W(BUS_W), .DEV_W(DEV_W)) u_screen (
        .bus(req_bus), .dev(req_dev), .bad(scr_bad)
    );

    cfgx_route #(.BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W),
                 .OFF_W(OFF_W), .TGT_W(TGT_W)) u_route (
        .bus(req_bus), .dev(req_dev), .fn(req_fn), .off(req_off),
        .bad(scr_bad), .route(rt), .packed_id(pid), .off_al(aoff)
    );

    // take a request when the result slot is empty or being drained
    assign req_ready = !rsp_valid || rsp_ready;
    assign acc       = req_valid && req_ready;

    // result register and the held remote target identifier
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_local  <= 1'b0;
            rsp_type   <= '0;
            rsp_target <= '0;
            rsp_off    <= '0;
            rsp_abort  <= 1'b0;
            rsp_err    <= 1'b0;
            rsp_rdata  <= '0;
        end else if (acc) begin
            rsp_valid <= 1'b1;
            rsp_local <= rt.is_local;
            rsp_type  <= rt.kind;
            rsp_off   <= aoff;
            rsp_abort <= rt.bad;
            rsp_err   <= rt.bad && req_write;
            rsp_rdata <= (rt.bad && !req_write) ? '1 : '0;
            if (!rt.bad && !rt.is_local) rsp_target <= pid;
        end else if (rsp_ready) begin
            rsp_valid <= 1'b0;
        end
    end

    a_r1_local_keeps_target: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_bus == '0) |=> (rsp_local && $stable(rsp_target)));
    a_r2_type_legal: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_type == 3'd4 || rsp_type == 3'd5));
    a_r4_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_off[1:0] == 2'b00));
    a_r5_bad_keeps_target: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && scr_bad) |=> (rsp_abort && $stable(rsp_target)));
    a_r6_bad_read_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && scr_bad && !req_write) |=> (rsp_rdata == '1 && !rsp_err));
    a_r7_bad_write_err: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && scr_bad && req_write) |=> rsp_err);
    a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rsp_valid);
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_off)
            && $stable(rsp_type) && $stable(rsp_abort) && $stable(rsp_local)));
endmodule

// File: tb/tb_cfg_xlate.sv
module tb_cfg_xlate;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
    logic [7:0]  req_bus = '0;
    logic [4:0]  req_dev = '0;
    logic [2:0]  req_fn = '0;
    logic [11:0] req_off = '0;
    logic        req_ready, rsp_valid, rsp_local, rsp_abort, rsp_err;
    logic [2:0]  rsp_type;
    logic [31:0] rsp_target, rsp_rdata;
    logic [11:0] rsp_off;

    cfg_xlate dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, fails = 0, cyc = 0;
    bit cmp_on = 1'b0;

    // behavioural reference state
    bit          m_v = 0, m_loc = 0, m_abort = 0, m_err = 0;
    int          m_type = 0;
    logic [31:0] m_tgt = 0, m_rd = 0;
    int          m_off = 0;

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // reference model updated on each rising edge
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_v = 0; m_tgt = 0;
        end else if (req_valid && (!m_v || rsp_ready)) begin
            bit bad;
            bad = (req_bus == 0 && req_dev > 1) || (req_bus == 1 && req_dev > 0);
            m_v = 1;
            m_loc = (req_bus == 0);
            m_type = (req_bus < 2) ? 4 : 5;
            m_off = int'(req_off) & 'hFFC;
            m_abort = bad;
            m_err = bad && req_write;
            m_rd = (bad && !req_write) ? 32'hFFFF_FFFF : 32'h0;
            if (!bad && req_bus != 0)
                m_tgt = (32'(req_bus) << 24) | (32'(req_dev) << 19) | (32'(req_fn) << 16);
        end else if (rsp_ready) begin
            m_v = 0;
        end
    end

    // compare against the model on every falling edge
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            chk(req_ready == (!m_v || rsp_ready), "R8 req_ready", 32'(req_ready), 32'(!m_v || rsp_ready));
            chk(rsp_valid == m_v, "R8 rsp_valid", 32'(rsp_valid), 32'(m_v));
            chk(rsp_target == m_tgt, "R3 rsp_target", rsp_target, m_tgt);
            if (m_v) begin
                chk(rsp_local == m_loc, "R1 rsp_local", 32'(rsp_local), 32'(m_loc));
                chk(int'(rsp_type) == m_type, "R2 rsp_type", 32'(rsp_type), 32'(m_type));
                chk(int'(rsp_off) == m_off, "R4 rsp_off", 32'(rsp_off), 32'(m_off));
                chk(rsp_abort == m_abort, "R5 rsp_abort", 32'(rsp_abort), 32'(m_abort));
                chk(rsp_err == m_err, "R7 rsp_err", 32'(rsp_err), 32'(m_err));
                chk(rsp_rdata == m_rd, "R6 rsp_rdata", rsp_rdata, m_rd);
            end
        end
    end

    task automatic send(input bit wr, input int bus, input int dev, input int fn, input int off);
        @(negedge clk);
        req_valid = 1; req_write = wr;
        req_bus = 8'(bus); req_dev = 5'(dev); req_fn = 3'(fn); req_off = 12'(off);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 0;
    endtask

    // watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        if (cyc == 50000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(rsp_valid == 0, "R9 reset valid", 32'(rsp_valid), 0);
        chk(rsp_target == 0, "R9 reset target", rsp_target, 0);
        rst_n = 1;
        cmp_on = 1;
        send(0, 2, 7, 3, 'h13);          // R3 remote type-1
        send(0, 0, 0, 0, 'h10);          // R1 local keeps target
        send(1, 0, 1, 5, 'h7);           // R1 device 1 valid on bus 0
        send(0, 0, 2, 0, 'h4);           // R5 R6 rejected read
        send(1, 1, 3, 0, 'h8);           // R5 R7 rejected write
        send(1, 1, 0, 6, 'hFFF);         // R2 R4 bus 1 type-0
        send(0, 255, 31, 7, 'hFFE);      // R3 all-ones fields
        send(0, 1, 1, 0, 0);             // R5 bus 1 device 1 rejected
        // R8: stall with a held result
        rsp_ready = 0;
        @(negedge clk); req_valid = 1; req_bus = 3; req_dev = 1; req_fn = 1; req_off = 'h20; req_write = 0;
        @(negedge clk); req_bus = 4;
        repeat (3) @(negedge clk);
        rsp_ready = 1;
        @(negedge clk); req_valid = 0;
        @(negedge clk);
        // mixed traffic under random back-pressure
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            rsp_ready = ($urandom % 4) != 0;
            req_valid = ($urandom % 4) != 0;
            req_write = $urandom % 2;
            case ($urandom % 4)
                0: req_bus = 0;
                1: req_bus = 1;
                2: req_bus = 2;
                default: req_bus = 8'($urandom);
            endcase
            req_dev = ($urandom % 2) ? 5'($urandom % 3) : 5'($urandom);
            req_fn = 3'($urandom);
            req_off = 12'($urandom);
        end
        @(negedge clk); req_valid = 0; rsp_ready = 1;
        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule